// File: doc/BRIEF.md
# Top-Relative Extended-Precision Register Stack

This block holds the floating-point operand registers of a stack-oriented arithmetic unit. Eight 80-bit slots form a push-down stack that is addressed relative to a rotating top pointer. Operand index `i` names the entry `i` places below the top, so index 0 is the top itself. A load pushes a value that becomes the new top. A store-and-pop hands the top value out and discards it. An arithmetic step reads the top and the entry at index `i` together. It writes its result back to either of them and may discard the top in the same cycle.

Both operand ports are combinational and follow the current pointer and index. A reverse control swaps which of the two entries appears on the first port, for non-commutative operations. Each slot carries a valid tag. An operation that would push onto an occupied slot, or that would consume an empty one, is refused: it leaves all state unchanged and raises a one-cycle fault flag in the following cycle. The operation decoder works through named states: IDLE (no state change), PUSH, POP and WRITE. Each of the last three resolves to either its accepted transition or its refused transition (REJECT_FULL, REJECT_EMPTY).

Top module: `fp_reg_stack`

## Requirements
- R1: After synchronous reset `top_ptr` is 0, both flags are 0 and every slot is empty, so a first POP is refused with `unf_flag`.
- R2: An accepted PUSH (op code 1) writes `push_data` to slot `top_ptr-1` mod 8, moves `top_ptr` down by one, and the value then reads as index 0.
- R3: A PUSH when eight entries are held raises `ovf_flag` for exactly the next cycle and leaves `top_ptr` and all entries unchanged.
- R4: `opnd_a` shows the top entry while a POP (op code 2) is presented; an accepted POP then moves `top_ptr` up by one and leaves one fewer entry.
- R5: A POP with an empty top, or a WRITE whose index 0 or index `idx` entry is empty, raises `unf_flag` for exactly the next cycle and changes no state.
- R6: With `rev`=0, `opnd_a` is the entry at index 0 and `opnd_b` is the entry at index `idx`, that is, physical slot (`top_ptr`+`idx`) mod 8.
- R7: With `rev`=1 the two operand ports exchange their values.
- R8: A WRITE (op code 3) with `wr_to_idx`=0 and `pop_en`=0 replaces the index 0 entry with `wr_data`.
- R9: A WRITE with `wr_to_idx`=1 and `pop_en`=0 replaces the index `idx` entry with `wr_data`; other entries are unchanged.
- R10: A WRITE with `pop_en`=1 stores the result first and then discards the top, so a result aimed at index `i` afterwards reads at index `i-1`.
- R11: IDLE (op code 0) changes no state, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | 0 idle, 1 push, 2 pop, 3 write |
| idx | input | 3 | Operand index relative to the top |
| rev | input | 1 | Swap the operand ports |
| wr_to_idx | input | 1 | WRITE target: 0 = index 0, 1 = index `idx` |
| pop_en | input | 1 | WRITE also discards the top |
| push_data | input | 80 | Value loaded by PUSH |
| wr_data | input | 80 | Result stored by WRITE |
| opnd_a | output | 80 | First operand |
| opnd_b | output | 80 | Second operand |
| top_ptr | output | 3 | Physical slot of the current top |
| ovf_flag | output | 1 | Push refused, one cycle after the request |
| unf_flag | output | 1 | Empty entry consumed, one cycle after the request |

## Verification
A pointer that moves wrongly shows on `top_ptr` one cycle after the operation. It also shows on the operand ports as soon as the next index is applied, because every value comes back at the wrong depth. A lost or stale valid tag appears later: a fault flag is wrong or missing on the first push or pop that reaches that slot, which can be several operations after the faulty update. The bench therefore keeps a depth-ordered model and compares both operand ports and both flags after every operation, with the stack often near full and near empty.

// File: rtl/fps_pkg.sv
package fps_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_WRITE = 2'd3
    } fps_op_e;
endpackage

// File: rtl/fps_tags.sv
module fps_tags #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_slot,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_slot,
    output logic [DEPTH-1:0] tags
);
    logic [DEPTH-1:0] tags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tags_q <= '0;
        end else begin
            if (set_en) tags_q[set_slot] <= 1'b1;
            if (clr_en) tags_q[clr_slot] <= 1'b0;
        end
    end

    assign tags = tags_q;

    assert_push_tags_R2: assert property (@(posedge clk) disable iff (rst)
        set_en && !clr_en |=> tags_q[$past(set_slot)]);

    assert_pop_clears_R4: assert property (@(posedge clk) disable iff (rst)
        clr_en && !set_en |=> !tags_q[$past(clr_slot)]);
endmodule

// File: rtl/fps_bank.sv
module fps_bank #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 80,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slot_q[waddr] <= wdata;
    end

    assign rdata_a = slot_q[raddr_a];
    assign rdata_b = slot_q[raddr_b];

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
        we ##1 (raddr_b == $past(waddr)) |-> rdata_b == $past(wdata));
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  fps_op_e          op,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_to_idx,
    input  logic             pop_en,
    input  logic [DEPTH-1:0] tags,
    output logic [IDX_W-1:0] tos,
    output logic [IDX_W-1:0] slot_b,
    output logic [IDX_W-1:0] slot_push,
    output logic             do_push,
    output logic             do_pop,
    output logic             do_write,
    output logic [IDX_W-1:0] wr_slot,
    output logic             ovf_flag,
    output logic             unf_flag
);
    logic [IDX_W-1:0] tos_q;
    logic             ovf_q, unf_q, ovf_n, unf_n;

    assign tos       = tos_q;
    assign slot_b    = IDX_W'(tos_q + idx);
    assign slot_push = IDX_W'(tos_q - 1'b1);

    // State register: top pointer and fault pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_n;
            unf_q <= unf_n;
            if (do_push)     tos_q <= slot_push;
            else if (do_pop) tos_q <= IDX_W'(tos_q + 1'b1);
        end
    end

    // Decode: each operation resolves to its accepted or refused transition
    always_comb begin
        do_push  = 1'b0;
        do_pop   = 1'b0;
        do_write = 1'b0;
        ovf_n    = 1'b0;
        unf_n    = 1'b0;
        wr_slot  = tos_q;
        unique case (op)
            OP_IDLE: ;
            OP_PUSH: begin
                if (tags[slot_push]) ovf_n = 1'b1;   // REJECT_FULL
                else                 do_push = 1'b1;
            end
            OP_POP: begin
                if (!tags[tos_q]) unf_n = 1'b1;      // REJECT_EMPTY
                else              do_pop = 1'b1;
            end
            OP_WRITE: begin
                if (!tags[tos_q] || !tags[slot_b]) begin
                    unf_n = 1'b1;                    // REJECT_EMPTY
                end else begin
                    do_write = 1'b1;
                    do_pop   = pop_en;
                    wr_slot  = wr_to_idx ? slot_b : tos_q;
                end
            end
            default: ;
        endcase
    end

    assign ovf_flag = ovf_q;
    assign unf_flag = unf_q;

    assert_push_moves_R2: assert property (@(posedge clk) disable iff (rst)
        do_push |=> tos_q == IDX_W'($past(tos_q) - 1'b1));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH) && tags[slot_push] |=> ovf_q && $stable(tos_q));

    assert_pop_moves_R4: assert property (@(posedge clk) disable iff (rst)
        do_pop |=> tos_q == IDX_W'($past(tos_q) + 1'b1));

    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_POP) && !tags[tos_q] |=> unf_q && $stable(tos_q));

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> $stable(tos_q) && !ovf_q && !unf_q);

    assert_flags_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(ovf_q && unf_q));
endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack
    import fps_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 80,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op,
    input  logic [IDX_W-1:0] idx,
    input  logic             rev,
    input  logic             wr_to_idx,
    input  logic             pop_en,
    input  logic [WIDTH-1:0] push_data,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] opnd_a,
    output logic [WIDTH-1:0] opnd_b,
    output logic [IDX_W-1:0] top_ptr,
    output logic             ovf_flag,
    output logic             unf_flag
);
    logic [DEPTH-1:0] tags;
    logic [IDX_W-1:0] tos, slot_b, slot_push, wr_slot;
    logic             do_push, do_pop, do_write;
    logic [WIDTH-1:0] top_val, idx_val;

    fps_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .op(fps_op_e'(op)), .idx(idx),
        .wr_to_idx(wr_to_idx), .pop_en(pop_en), .tags(tags),
        .tos(tos), .slot_b(slot_b), .slot_push(slot_push),
        .do_push(do_push), .do_pop(do_pop), .do_write(do_write),
        .wr_slot(wr_slot), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    fps_tags #(.DEPTH(DEPTH)) u_tags (
        .clk(clk), .rst(rst),
        .set_en(do_push), .set_slot(slot_push),
        .clr_en(do_pop), .clr_slot(tos),
        .tags(tags)
    );

    fps_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
        .clk(clk), .rst(rst),
        .we(do_push || do_write),
        .waddr(do_push ? slot_push : wr_slot),
        .wdata(do_push ? push_data : wr_data),
        .raddr_a(tos), .raddr_b(slot_b),
        .rdata_a(top_val), .rdata_b(idx_val)
    );

    assign opnd_a  = rev ? idx_val : top_val;
    assign opnd_b  = rev ? top_val : idx_val;
    assign top_ptr = tos;
endmodule

// File: tb/fp_reg_stack_test.sv
module fp_reg_stack_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  op;
    logic [2:0]  idx;
    logic        rev, wr_to_idx, pop_en;
    logic [79:0] push_data, wr_data;
    logic [79:0] opnd_a, opnd_b;
    logic [2:0]  top_ptr;
    logic        ovf_flag, unf_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Depth-ordered model: m_stk[0] is the top
    logic [79:0] m_stk [8];
    int          m_cnt;
    logic [2:0]  m_top;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_reg_stack uut (
        .clk(clk), .rst(rst), .op(op), .idx(idx), .rev(rev),
        .wr_to_idx(wr_to_idx), .pop_en(pop_en), .push_data(push_data),
        .wr_data(wr_data), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .top_ptr(top_ptr), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    function automatic logic [79:0] rnd80();
        return {$urandom(), $urandom(), $urandom()} & {16'hffff, 64'hffff_ffff_ffff_ffff};
    endfunction

    task automatic check(string req, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_pop();
        for (int k = 0; k < 7; k++) m_stk[k] = m_stk[k+1];
        m_cnt--;
        m_top = m_top + 3'd1;
    endtask

    // One operation: drive at negedge, check operands, check result after edge
    task automatic do_op(logic [1:0] o, logic [2:0] i, logic r, logic ti, logic pe,
                         logic [79:0] pd, logic [79:0] wd);
        bit exp_ovf, exp_unf;
        @(negedge clk);
        op = o; idx = i; rev = r; wr_to_idx = ti; pop_en = pe;
        push_data = pd; wr_data = wd;
        #1;
        if (m_cnt > 0) check(r ? "R7 opnd_b top" : "R6 opnd_a top", r ? opnd_b : opnd_a, m_stk[0]);
        if (int'(i) < m_cnt) check(r ? "R7 opnd_a idx" : "R6 opnd_b idx", r ? opnd_a : opnd_b, m_stk[i]);
        exp_ovf = 1'b0; exp_unf = 1'b0;
        case (o)
            2'd1: if (m_cnt == 8) exp_ovf = 1'b1;
                  else begin
                      for (int k = 7; k > 0; k--) m_stk[k] = m_stk[k-1];
                      m_stk[0] = pd; m_cnt++; m_top = m_top - 3'd1;
                  end
            2'd2: if (m_cnt == 0) exp_unf = 1'b1; else model_pop();
            2'd3: if (m_cnt == 0 || int'(i) >= m_cnt) exp_unf = 1'b1;
                  else begin
                      m_stk[ti ? int'(i) : 0] = wd;
                      if (pe) model_pop();
                  end
            default: ;
        endcase
        @(negedge clk);
        check(exp_ovf ? "R3 ovf_flag" : "R11 ovf_flag", 80'(ovf_flag), 80'(exp_ovf));
        check(exp_unf ? "R5 unf_flag" : "R11 unf_flag", 80'(unf_flag), 80'(exp_unf));
        check(o == 2'd1 ? "R2 top_ptr" : (o == 2'd2 ? "R4 top_ptr" : "R10 top_ptr"),
              80'(top_ptr), 80'(m_top));
        op = 2'd0;
    endtask

    task automatic sweep(string req);
        @(negedge clk);
        op = 2'd0; rev = 1'b0;
        for (int k = 0; k < m_cnt; k++) begin
            idx = 3'(k);
            #1;
            check(req, opnd_b, m_stk[k]);
        end
    endtask

    initial begin
        for (int k = 0; k < 8; k++) m_stk[k] = '0;
        m_cnt = 0; m_top = 3'd0;
        op = 2'd0; idx = '0; rev = 0; wr_to_idx = 0; pop_en = 0;
        push_data = '0; wr_data = '0;
        void'($urandom(32'd20121));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, then an empty pop is refused
        check("R1 top_ptr", 80'(top_ptr), 80'd0);
        check("R1 ovf_flag", 80'(ovf_flag), 80'd0);
        check("R1 unf_flag", 80'(unf_flag), 80'd0);
        do_op(2'd2, 3'd0, 0, 0, 0, '0, '0);
        // R2 / R3: fill to eight, then a ninth push is refused
        for (int k = 0; k < 8; k++) do_op(2'd1, 3'd0, 0, 0, 0, rnd80(), '0);
        do_op(2'd1, 3'd0, 0, 0, 0, 80'h1234, '0);
        sweep("R3 contents after refused push");
        // R8, R9, R7
        do_op(2'd3, 3'd5, 1, 0, 0, '0, rnd80());
        do_op(2'd3, 3'd7, 0, 1, 0, '0, rnd80());
        sweep("R9 contents after index write");
        // R10: write to index 3 with pop; result reads at index 2
        do_op(2'd3, 3'd3, 0, 1, 1, '0, 80'hABCD_0000_1111);
        @(negedge clk); idx = 3'd2; #1;
        check("R10 result at idx-1", opnd_b, 80'hABCD_0000_1111);
        // R5: index beyond depth during write
        do_op(2'd3, 3'd7, 0, 1, 0, '0, rnd80());
        sweep("R5 contents after refused write");
        // R4: drain past empty
        for (int k = 0; k < 9; k++) do_op(2'd2, 3'd0, 0, 0, 0, '0, '0);
        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [1:0] o;
            int sel = int'($urandom_range(0, 9));
            o = (sel < 4) ? 2'd1 : (sel < 6) ? 2'd2 : (sel < 9) ? 2'd3 : 2'd0;
            do_op(o, 3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
                  1'($urandom_range(0, 3) == 0), rnd80(), rnd80());
        end
        sweep("R6 final contents");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule